// File: doc/BRIEF.md
# Accumulator Machine Sequencing Controller

This block is the hardwired control unit of a small 16-bit accumulator computer. It walks every instruction through four phases: address set, fetch, decode and execute. It keeps the phase in a two-bit register whose code changes by one bit per step, so the phases form a Gray cycle. In each phase it raises the load and select enables that move words between the program counter, the memory address register, the instruction register, the accumulator and the memory.

The instruction register, the accumulator, the counters and the memory all sit outside the block. The controller receives only the 6-bit opcode field of the held instruction and the accumulator sign bit. From the phase and that opcode it derives a one-hot execute strobe and the transfer enables for that instruction. An opcode outside the defined set still takes a full four-phase pass, but nothing is loaded or written during its execute phase.

An instruction word carries the opcode in bits 15..10 and a memory address in bits 9..0.

Top module: `acc_cpu_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the phase becomes address set: `phase_code` = 2'b00 and `ph_addr` = 1. The first cycle after reset is therefore an address-set cycle.
- R2: The phase codes are address set 2'b00, fetch 2'b01, decode 2'b11 and execute 2'b10. They advance in that cyclic order, one step per clock, so exactly one bit changes on each step. Exactly one of `ph_addr`, `ph_fetch`, `ph_decode`, `ph_exec` is high, and it matches the code.
- R3: In the address-set phase `mar_load`=1 with `mar_src`=0 (the address register takes the program counter) and `iar_inc`=1. No other enable is high.
- R4: In the fetch phase only `ir_load` is high, which loads the instruction register from memory at the address register.
- R5: In the decode phase `mar_load`=1 with `mar_src`=1, which loads the address register from bits 9..0 of the instruction. No other enable is high.
- R6: `ex_strobe` is zero outside the execute phase. In the execute phase it is one-hot for the defined opcodes: bit0 for load (opcode 4), bit1 for store (8), bit2 for add (16), bit3 for branch (32) and bit4 for branch-if-positive (33).
- R7: Load raises `acc_load` with `acc_src`=0 (memory word). Add raises `acc_load` with `acc_src`=1 (accumulator plus memory word). Store raises `mem_wr`, which writes the accumulator.
- R8: Branch raises `iar_ld`, which loads the program counter from address bits 9..0.
- R9: Branch-if-positive raises `iar_ld` only when `acc_sign` is 0, that is, when the accumulator is zero or positive.
- R10: An undefined opcode in the execute phase raises no strobe and no enable, and the next phase is address set.
- R11: Every instruction takes exactly four clock cycles from one address-set cycle to the next.
- R12: With a datapath attached, the program load 3, add 4, store 5 (data words 7 and 9) leaves 16 in the accumulator and 16 in word 5 after twelve cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 6 | Opcode field of the held instruction |
| acc_sign | input | 1 | Accumulator bit 15 |
| phase_code | output | 2 | Encoded phase register |
| ph_addr | output | 1 | Address-set phase |
| ph_fetch | output | 1 | Fetch phase |
| ph_decode | output | 1 | Decode phase |
| ph_exec | output | 1 | Execute phase |
| ex_strobe | output | 5 | One-hot execute operation |
| mar_load | output | 1 | Load address register |
| mar_src | output | 1 | Address register source: 0 program counter, 1 instruction address field |
| iar_inc | output | 1 | Increment program counter |
| iar_ld | output | 1 | Load program counter from address field |
| ir_load | output | 1 | Load instruction register from memory |
| acc_load | output | 1 | Load accumulator |
| acc_src | output | 1 | Accumulator source: 0 memory, 1 sum |
| mem_wr | output | 1 | Write accumulator to memory |

## Verification
Several rules are checked on every cycle: the single-bit phase step and the return to address set after execute, a one-hot execute strobe that appears only in the execute phase, the sign gate on the conditional branch, store and branch enables that stay bound to their strobes, and the four-cycle spacing between address-set cycles. The exact enable pattern in each phase and each opcode's effect on the accumulator, memory and program counter can only be shown by the bench's scenarios. These scenarios are the arithmetic program, the taken and not-taken conditional branch, the undefined opcode, the unconditional jump, and a reset in the middle of an instruction.

// File: rtl/acc_ctl_pkg.sv
package acc_ctl_pkg;

    localparam int OP_W   = 6;
    localparam int ADR_W  = 10;
    localparam int WORD_W = 16;
    localparam int N_OPS  = 5;

    // execute strobe bit positions
    localparam int X_LOAD  = 0;
    localparam int X_STORE = 1;
    localparam int X_ADD   = 2;
    localparam int X_JUMP  = 3;
    localparam int X_JPOS  = 4;

    localparam logic [OP_W-1:0] OP_TABLE [N_OPS] = '{6'd4, 6'd8, 6'd16, 6'd32, 6'd33};

    typedef enum logic [1:0] {
        PH_ADDR   = 2'b00,
        PH_FETCH  = 2'b01,
        PH_DECODE = 2'b11,
        PH_EXEC   = 2'b10
    } phase_e;

    typedef struct packed {
        logic mar_load;
        logic mar_src;
        logic iar_inc;
        logic iar_ld;
        logic ir_load;
        logic acc_load;
        logic acc_src;
        logic mem_wr;
    } xfer_t;

    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH_ADDR:   phase_after = PH_FETCH;
            PH_FETCH:  phase_after = PH_DECODE;
            PH_DECODE: phase_after = PH_EXEC;
            default:   phase_after = PH_ADDR;
        endcase
    endfunction

endpackage

// File: rtl/acc_phase_seq.sv
module acc_phase_seq
    import acc_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_ADDR;
        else     phase_q <= phase_after(phase_q);
    end

    assign phase = phase_q;

    // R2
    gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(phase_q ^ $past(phase_q)) == 1));

    // R10
    exec_return_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC) |=> (phase_q == PH_ADDR));

endmodule

// File: rtl/acc_op_decode.sv
module acc_op_decode
    import acc_ctl_pkg::*;
#(
    parameter int OPW  = OP_W,
    parameter int NOPS = N_OPS
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_e          phase,
    input  logic [OPW-1:0]  op,
    output logic [NOPS-1:0] ex
);

    logic in_exec;
    assign in_exec = (phase == PH_EXEC);

    for (genvar i = 0; i < NOPS; i++) begin : g_match
        assign ex[i] = in_exec && (op == OPW'(OP_TABLE[i]));
    end

    // R6
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ex));

    // R6
    strobe_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (ex != '0) |-> (phase == PH_EXEC));

endmodule

// File: rtl/acc_xfer_ctrl.sv
module acc_xfer_ctrl
    import acc_ctl_pkg::*;
#(
    parameter int NOPS = N_OPS
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_e          phase,
    input  logic [NOPS-1:0] ex,
    input  logic            acc_sign,
    output xfer_t           xf
);

    always_comb begin
        xf = '0;
        case (phase)
            PH_ADDR: begin
                xf.mar_load = 1'b1;
                xf.mar_src  = 1'b0;
                xf.iar_inc  = 1'b1;
            end
            PH_FETCH: begin
                xf.ir_load = 1'b1;
            end
            PH_DECODE: begin
                xf.mar_load = 1'b1;
                xf.mar_src  = 1'b1;
            end
            default: begin
                xf.acc_load = ex[X_LOAD] | ex[X_ADD];
                xf.acc_src  = ex[X_ADD];
                xf.mem_wr   = ex[X_STORE];
                xf.iar_ld   = ex[X_JUMP] | (ex[X_JPOS] & ~acc_sign);
            end
        endcase
    end

    // R9
    cond_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (ex[X_JPOS] && acc_sign) |-> !xf.iar_ld);

    // R7
    store_bind_chk: assert property (@(posedge clk) disable iff (rst)
        xf.mem_wr |-> ex[X_STORE]);

    // R8
    branch_bind_chk: assert property (@(posedge clk) disable iff (rst)
        ex[X_JUMP] |-> xf.iar_ld);

    // R10
    idle_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && ex == '0) |-> (xf == '0));

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  op_code,
    input  logic             acc_sign,
    output logic [1:0]       phase_code,
    output logic             ph_addr,
    output logic             ph_fetch,
    output logic             ph_decode,
    output logic             ph_exec,
    output logic [N_OPS-1:0] ex_strobe,
    output logic             mar_load,
    output logic             mar_src,
    output logic             iar_inc,
    output logic             iar_ld,
    output logic             ir_load,
    output logic             acc_load,
    output logic             acc_src,
    output logic             mem_wr
);

    phase_e phase;
    xfer_t  xf;

    acc_phase_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    acc_op_decode #(.OPW(OP_W), .NOPS(N_OPS)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .op    (op_code),
        .ex    (ex_strobe)
    );

    acc_xfer_ctrl #(.NOPS(N_OPS)) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .ex       (ex_strobe),
        .acc_sign (acc_sign),
        .xf       (xf)
    );

    assign phase_code = phase;
    assign ph_addr    = (phase == PH_ADDR);
    assign ph_fetch   = (phase == PH_FETCH);
    assign ph_decode  = (phase == PH_DECODE);
    assign ph_exec    = (phase == PH_EXEC);

    assign mar_load = xf.mar_load;
    assign mar_src  = xf.mar_src;
    assign iar_inc  = xf.iar_inc;
    assign iar_ld   = xf.iar_ld;
    assign ir_load  = xf.ir_load;
    assign acc_load = xf.acc_load;
    assign acc_src  = xf.acc_src;
    assign mem_wr   = xf.mem_wr;

    // spacing counter for the instruction-length check
    logic [2:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= 3'd0;
            seen_q <= 1'b0;
        end else if (ph_addr) begin
            gap_q  <= 3'd1;
            seen_q <= 1'b1;
        end else if (gap_q != 3'd7) begin
            gap_q  <= gap_q + 3'd1;
        end
    end

    // R11
    instr_len_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_addr && seen_q) |-> (gap_q == 3'd4));

    // R2
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({ph_addr, ph_fetch, ph_decode, ph_exec}));

    // R1
    reset_phase_chk: assert property (@(posedge clk)
        rst |=> ph_addr);

endmodule

// File: tb/tb_acc_cpu_ctrl.sv
`timescale 1ns/1ps
module tb_acc_cpu_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  op_code;
    logic        acc_sign;
    logic [1:0]  phase_code;
    logic        ph_addr, ph_fetch, ph_decode, ph_exec;
    logic [4:0]  ex_strobe;
    logic        mar_load, mar_src, iar_inc, iar_ld, ir_load, acc_load, acc_src, mem_wr;

    always #2.5 clk = ~clk;

    acc_cpu_ctrl dut (
        .clk(clk), .rst(rst), .op_code(op_code), .acc_sign(acc_sign),
        .phase_code(phase_code), .ph_addr(ph_addr), .ph_fetch(ph_fetch),
        .ph_decode(ph_decode), .ph_exec(ph_exec), .ex_strobe(ex_strobe),
        .mar_load(mar_load), .mar_src(mar_src), .iar_inc(iar_inc), .iar_ld(iar_ld),
        .ir_load(ir_load), .acc_load(acc_load), .acc_src(acc_src), .mem_wr(mem_wr)
    );

    // datapath model
    logic [15:0] mem [64];
    logic [15:0] ir, acc;
    logic [9:0]  iar, mar;

    assign op_code  = ir[15:10];
    assign acc_sign = acc[15];

    always @(posedge clk) begin
        if (rst) begin
            iar <= '0; mar <= '0; ir <= '0; acc <= '0;
        end else begin
            if (iar_inc)      iar <= iar + 10'd1;
            else if (iar_ld)  iar <= ir[9:0];
            if (mar_load)     mar <= mar_src ? ir[9:0] : iar;
            if (ir_load)      ir  <= mem[mar[5:0]];
            if (acc_load)     acc <= acc_src ? acc + mem[mar[5:0]] : mem[mar[5:0]];
            if (mem_wr)       mem[mar[5:0]] <= acc;
        end
    end

    // scoreboard
    typedef struct {
        logic [18:0] v;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_chk  = 0;
    int n_fail = 0;

    function automatic logic [18:0] exp_vec(input logic [1:0] ph, input logic [5:0] op, input logic s);
        logic [3:0] phs;
        logic [4:0] ex;
        logic [7:0] en;
        phs = 4'b0; ex = 5'b0; en = 8'b0;
        // en = {mar_load, mar_src, iar_inc, iar_ld, ir_load, acc_load, acc_src, mem_wr}
        case (ph)
            2'b00: begin phs = 4'b0001; en = 8'b1010_0000; end
            2'b01: begin phs = 4'b0010; en = 8'b0000_1000; end
            2'b11: begin phs = 4'b0100; en = 8'b1100_0000; end
            default: begin
                phs = 4'b1000;
                case (op)
                    6'd4:  begin ex = 5'b00001; en = 8'b0000_0100; end
                    6'd8:  begin ex = 5'b00010; en = 8'b0000_0001; end
                    6'd16: begin ex = 5'b00100; en = 8'b0000_0110; end
                    6'd32: begin ex = 5'b01000; en = 8'b0001_0000; end
                    6'd33: begin ex = 5'b10000; en = {3'b000, ~s, 4'b0000}; end
                    default: ;
                endcase
            end
        endcase
        return {ph, phs, ex, en};
    endfunction

    task automatic push_instr(input logic [5:0] op, input logic s, input string tag);
        sb.push_back('{exp_vec(2'b00, op, s), "R3 R2"});
        sb.push_back('{exp_vec(2'b01, op, s), "R4 R2"});
        sb.push_back('{exp_vec(2'b11, op, s), "R5 R2"});
        sb.push_back('{exp_vec(2'b10, op, s), tag});
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            logic [18:0] act;
            it  = sb.pop_front();
            act = {phase_code, ph_exec, ph_decode, ph_fetch, ph_addr, ex_strobe,
                   mar_load, mar_src, iar_inc, iar_ld, ir_load, acc_load, acc_src, mem_wr};
            check(act === it.v, it.tag, 32'(act), 32'(it.v));
        end
    end

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic start_run();
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        mem[0] = 16'h1003;   // load 3
        mem[1] = 16'h4004;   // add 4
        mem[2] = 16'h2005;   // store 5
        mem[3] = 16'h0007;
        mem[4] = 16'h0009;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(phase_code == 2'b00 && ph_addr && !ph_fetch && !ph_decode && !ph_exec,
              "R1 reset phase", 32'(phase_code), 32'h0);

        // Scenario 1: arithmetic program (R12, R7)
        push_instr(6'd4,  1'b0, "R6 R7 load");
        push_instr(6'd16, 1'b0, "R6 R7 add");
        push_instr(6'd8,  1'b0, "R6 R7 store");
        start_run();
        wait (sb.size() == 0);
        @(posedge clk);
        #1;
        check(acc == 16'd16, "R12 accumulator", 32'(acc), 32'd16);
        check(mem[5] == 16'd16, "R12 memory word 5", 32'(mem[5]), 32'd16);
        check(iar == 10'd3, "R12 program counter", 32'(iar), 32'd3);

        // Scenario 2: branches and undefined opcode (R8, R9, R10)
        rst = 1'b1;
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        mem[0]  = 16'h100A;  // load 10
        mem[1]  = 16'h8405;  // branch-if-positive 5 (not taken)
        mem[2]  = 16'h100B;  // load 11
        mem[3]  = 16'h8406;  // branch-if-positive 6 (taken)
        mem[6]  = 16'hFC00;  // undefined opcode 63
        mem[7]  = 16'h8000;  // branch 0
        mem[10] = 16'h8000;
        mem[11] = 16'h0001;
        repeat (2) @(posedge clk);
        push_instr(6'd4,  1'b0, "R6 R7 load negative");
        push_instr(6'd33, 1'b1, "R9 not taken");
        push_instr(6'd4,  1'b1, "R6 R7 load positive");
        push_instr(6'd33, 1'b0, "R9 taken");
        push_instr(6'd63, 1'b0, "R10 undefined opcode");
        push_instr(6'd32, 1'b0, "R8 branch");
        push_instr(6'd4,  1'b0, "R8 R11 target load");
        start_run();
        wait (sb.size() == 0);
        @(posedge clk);
        #1;
        check(acc == 16'h8000, "R8 accumulator after jump target", 32'(acc), 32'h8000);
        check(iar == 10'd1, "R8 program counter after jump target", 32'(iar), 32'd1);
        @(negedge clk);
        check(ph_addr && phase_code == 2'b00, "R11 next instruction start", 32'(phase_code), 32'h0);

        // Scenario 3: reset in the middle of an instruction (R1)
        @(posedge clk);
        #1 rst = 1'b1;
        @(negedge clk);
        check(ph_fetch && phase_code == 2'b01, "R2 fetch before reset edge", 32'(phase_code), 32'h1);
        @(posedge clk);
        @(negedge clk);
        check(ph_addr && phase_code == 2'b00 && ex_strobe == 5'b0,
              "R1 mid-instruction reset", 32'(phase_code), 32'h0);
        #1 rst = 1'b0;
        @(negedge clk);
        check(ph_fetch && ir_load && phase_code == 2'b01, "R2 R4 first step after reset",
              32'(phase_code), 32'h1);

        finish_run();
    end

endmodule